// File: doc/BRIEF.md
# Round-Robin Bus Arbiter with Parking

This block is the central arbiter of a shared parallel bus with several initiator agents. Each agent raises an active-low request and receives an active-low grant. Owners change in round-robin order, so an agent that keeps requesting is always served within one full turn of the other agents.

While no other agent is asking for the bus, the current owner keeps its grant. This is bus parking, and it lets an owner start its next transaction without going through arbitration again. One agent, a legacy bridge chosen by a parameter, is never parked on. When the bridge stops requesting and nobody else is waiting, its grant is withdrawn and the bus parks on a default agent instead.

A handover from one owner to the next always passes through at least one cycle with no grant. A new grant is issued only when the bus-idle input shows that the previous transaction has ended. The requests are registered before arbitration, so grants change only on clock edges.

Top module: `rr_park_arb`

## Requirements
- R1: Bit i of `req_ni` low means agent i requests, and bit i of `gnt_no` low means agent i holds the grant (four agents by default). Requests are registered before arbitration, so a change at `req_ni` can affect `gnt_no` no earlier than the second rising clock edge after it.
- R2: At most one bit of `gnt_no` is low in any cycle.
- R3: The grant never moves directly from one agent to another; every change of owner passes through at least one cycle with all grants deasserted.
- R4: While no grant is asserted, a new grant is issued only at a clock edge where `bus_idle_i` is high; otherwise all grants stay deasserted.
- R5: The next owner is the first agent with a registered request found by scanning upward, with wrap-around, from the agent just after the last agent granted because it requested. That position is agent 0 after reset. A grant given only for parking does not move the position.
- R6: An owner other than the bridge keeps its grant, even after dropping its own request, for as long as no other agent has a registered request.
- R7: When any agent other than the current owner has a registered request, the owner's grant is deasserted at the next clock edge.
- R8: The bridge agent (`BRIDGE_IDX`, default 0) keeps its grant while it is the only requester. Once no registered request remains, its grant is deasserted at the next clock edge.
- R9: With no grant asserted, no registered request and `bus_idle_i` high, the grant goes to the default parking agent (`PARK_IDX`, default 1, which must differ from `BRIDGE_IDX`).
- R10: During and right after reset all grants are deasserted, and the rotation position is agent 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_ni | input | N_AGENTS | Bus requests, active low, one per agent |
| bus_idle_i | input | 1 | High when the previous bus transaction has finished |
| gnt_no | output | N_AGENTS | Bus grants, active low, one per agent |

## Verification
The bench sweeps every starting owner against all sixteen request patterns. After each pattern it checks the grant at the first, second and third clock edges.

These sweeps catch the following faults:
- An arbiter that skips the request register would react one edge early.
- An arbiter that parks on the bridge would keep agent 0 granted with nothing requested.
- An arbiter that hands over without a gap would show the new grant one cycle early.
- A wrong rotation start would pick a different winner among several requesters.

Separate runs cover the remaining cases. A continuous all-request run checks that owners step 0, 1, 2, 3 with an empty cycle between each pair. A run that holds `bus_idle_i` low checks that no grant appears while the bus is busy.

// File: rtl/rr_park_arb_pkg.sv
package rr_park_arb_pkg;
  typedef enum logic {
    ST_GAP = 1'b0,
    ST_OWN = 1'b1
  } arb_state_e;
endpackage

// File: rtl/rr_park_arb_req_sync.sv
module rr_park_arb_req_sync #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_ni,
  output logic [N-1:0] req_o
);
  for (genvar g = 0; g < N; g++) begin : g_req
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) req_o[g] <= 1'b0;
      else         req_o[g] <= ~req_ni[g];
    end
  end
endmodule

// File: rtl/rr_park_arb_pick.sv
module rr_park_arb_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] ptr_i,
  output logic          vld_o,
  output logic [IW-1:0] idx_o
);
  int c;
  // scan downward so the smallest offset from ptr wins
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    c     = 0;
    for (int i = N - 1; i >= 0; i--) begin
      c = (int'(ptr_i) + i) % N;
      if (req_i[c]) begin
        vld_o = 1'b1;
        idx_o = IW'(c);
      end
    end
  end
endmodule

// File: rtl/rr_park_arb_ctrl.sv
module rr_park_arb_ctrl
  import rr_park_arb_pkg::*;
#(
  parameter int N          = 4,
  parameter int IW         = 2,
  parameter int BRIDGE_IDX = 0,
  parameter int PARK_IDX   = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  req_i,
  input  logic          bus_idle_i,
  input  logic          pick_vld_i,
  input  logic [IW-1:0] pick_idx_i,
  output logic [IW-1:0] ptr_o,
  output logic [N-1:0]  gnt_o
);
  arb_state_e    st_q, st_d;
  logic [IW-1:0] own_q, own_d, ptr_d;
  logic [N-1:0]  own_oh, others;
  logic          bridge_own;

  assign own_oh     = {{(N-1){1'b0}}, 1'b1} << own_q;
  assign others     = req_i & ~own_oh;
  assign bridge_own = (own_q == IW'(BRIDGE_IDX));

  always_comb begin
    st_d  = st_q;
    own_d = own_q;
    ptr_d = ptr_o;
    case (st_q)
      ST_OWN: begin
        if (|others || (bridge_own && !req_i[BRIDGE_IDX])) st_d = ST_GAP;
      end
      default: begin
        if (bus_idle_i) begin
          st_d = ST_OWN;
          if (pick_vld_i) begin
            own_d = pick_idx_i;
            ptr_d = (pick_idx_i == IW'(N - 1)) ? '0 : pick_idx_i + IW'(1);
          end else begin
            own_d = IW'(PARK_IDX);
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_GAP;
      own_q <= '0;
      ptr_o <= '0;
    end else begin
      st_q  <= st_d;
      own_q <= own_d;
      ptr_o <= ptr_d;
    end
  end

  assign gnt_o = (st_q == ST_OWN) ? own_oh : '0;
endmodule

// File: rtl/rr_park_arb.sv
module rr_park_arb #(
  parameter int N_AGENTS   = 4,
  parameter int BRIDGE_IDX = 0,
  parameter int PARK_IDX   = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_AGENTS-1:0] req_ni,
  input  logic                bus_idle_i,
  output logic [N_AGENTS-1:0] gnt_no
);
  localparam int IW = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1;

  logic [N_AGENTS-1:0] req_q, gnt_q;
  logic [IW-1:0]       ptr, pick_idx;
  logic                pick_vld;

  rr_park_arb_req_sync #(.N(N_AGENTS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_ni (req_ni),
    .req_o  (req_q)
  );

  rr_park_arb_pick #(.N(N_AGENTS), .IW(IW)) u_pick (
    .req_i (req_q),
    .ptr_i (ptr),
    .vld_o (pick_vld),
    .idx_o (pick_idx)
  );

  rr_park_arb_ctrl #(
    .N(N_AGENTS), .IW(IW), .BRIDGE_IDX(BRIDGE_IDX), .PARK_IDX(PARK_IDX)
  ) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_q),
    .bus_idle_i (bus_idle_i),
    .pick_vld_i (pick_vld),
    .pick_idx_i (pick_idx),
    .ptr_o      (ptr),
    .gnt_o      (gnt_q)
  );

  assign gnt_no = ~gnt_q;
endmodule

// File: rtl/rr_park_arb_chk.sv
module rr_park_arb_chk #(
  parameter int N_AGENTS   = 4,
  parameter int BRIDGE_IDX = 0,
  parameter int PARK_IDX   = 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [N_AGENTS-1:0] req_q,
  input logic                bus_idle_i,
  input logic [N_AGENTS-1:0] gnt_no
);
  logic [N_AGENTS-1:0] g;
  assign g = ~gnt_no;

  p_onehot_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(g));

  p_no_direct_handover_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|g) |=> (g == '0 || g == $past(g)));

  p_wait_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g == '0 && !bus_idle_i) |=> (g == '0));

  p_park_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|g) && !g[BRIDGE_IDX] && ((req_q & ~g) == '0)) |=> (g == $past(g)));

  p_preempt_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|g) && ((req_q & ~g) != '0)) |=> (g == '0));

  p_bridge_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g[BRIDGE_IDX] && req_q == g) |=> (g == $past(g)));

  p_bridge_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g[BRIDGE_IDX] && req_q == '0) |=> (g == '0));

  p_default_park_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (g == '0 && req_q == '0 && bus_idle_i) |=>
      (g == ({{(N_AGENTS-1){1'b0}}, 1'b1} << PARK_IDX)));
endmodule

bind rr_park_arb rr_park_arb_chk #(
  .N_AGENTS(N_AGENTS), .BRIDGE_IDX(BRIDGE_IDX), .PARK_IDX(PARK_IDX)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_q      (req_q),
  .bus_idle_i (bus_idle_i),
  .gnt_no     (gnt_no)
);

// File: tb/rr_park_arb_tb_top.sv
module rr_park_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 4;
  localparam int BRIDGE     = 0;
  localparam int PARK       = 1;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_ni = '1;
  logic         bus_idle_i = 1'b0;
  logic [N-1:0] gnt_no;
  int           checks = 0;
  int           errors = 0;
  bit           done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rr_park_arb #(.N_AGENTS(N), .BRIDGE_IDX(BRIDGE), .PARK_IDX(PARK)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .req_ni     (req_ni),
    .bus_idle_i (bus_idle_i),
    .gnt_no     (gnt_no)
  );

  function automatic logic [N-1:0] oh(int i);
    return {{(N-1){1'b0}}, 1'b1} << i;
  endfunction

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s grant act %b exp %b", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // reset with req pattern held, bus busy; owner o after bus goes idle
  task automatic start_owner(int o);
    rst_ni     = 1'b0;
    bus_idle_i = 1'b0;
    req_ni     = ~oh(o);
    tick();
    check("R10 reset", ~gnt_no, '0);
    rst_ni = 1'b1;
    tick();
    tick();
    check("R4 busy no grant", ~gnt_no, '0);
    bus_idle_i = 1'b1;
    tick();
    check("R4 grant on idle", ~gnt_no, oh(o));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // sweep: every owner against every request pattern
    for (int o = 0; o < N; o++) begin
      for (int p = 0; p < (1 << N); p++) begin
        logic [N-1:0] pv, others, e1, e2;
        string        t1, t2;
        int           win;
        start_owner(o);
        pv     = N'(p);
        others = pv & ~oh(o);
        win    = -1;
        for (int k = N; k > 0; k--) begin
          int c;
          c = (o + k) % N;
          if (pv[c]) win = c;
        end
        if (others != '0) begin
          e1 = '0;     t1 = "R7 preempt";
          e2 = oh(win); t2 = "R5 rotation winner";
        end else if (o == BRIDGE && !pv[BRIDGE]) begin
          e1 = '0;      t1 = "R8 bridge release";
          e2 = oh(PARK); t2 = "R9 default park";
        end else begin
          e1 = oh(o); e2 = oh(o);
          t1 = (o == BRIDGE) ? "R8 bridge hold" : "R6 park hold";
          t2 = t1;
        end
        req_ni = ~pv;
        tick();
        check("R1 registered request", ~gnt_no, oh(o));
        tick();
        check(t1, ~gnt_no, e1);
        tick();
        check(t2, ~gnt_no, e2);
      end
    end

    // continuous requests from all: owners step in order with gaps
    begin
      logic [N-1:0] last, cur;
      int           expect_own, seen_gap, changes;
      start_owner(0);
      req_ni     = '0;
      last       = oh(0);
      expect_own = 1;
      seen_gap   = 0;
      changes    = 0;
      while (changes < 8) begin
        tick();
        cur = ~gnt_no;
        check("R2 single grant", N'($countones(cur) <= 1), N'(1));
        if (cur == '0) seen_gap = 1;
        else if (cur != last) begin
          check("R3 gap before handover", N'(seen_gap), N'(1));
          check("R5 rotation order", cur, oh(expect_own));
          expect_own = (expect_own + 1) % N;
          last       = cur;
          seen_gap   = 0;
          changes++;
        end
      end
    end

    // busy bus holds back the next owner
    start_owner(2);
    bus_idle_i = 1'b0;
    req_ni     = ~(oh(2) | oh(3));
    tick();
    tick();
    check("R7 preempt while busy", ~gnt_no, '0);
    for (int i = 0; i < 4; i++) begin
      tick();
      check("R4 hold while busy", ~gnt_no, '0);
    end
    bus_idle_i = 1'b1;
    tick();
    check("R4 grant after idle", ~gnt_no, oh(3));

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule